// File: doc/BRIEF.md
# Supervisory Watchdog with Stretched Reset Pulse

This block watches a processor for signs of life and produces an active-low reset request. Software picks a timeout with a 5-bit code. The timeout is a multiple of 100 ms, and the block counts it on a 1 ms tick that comes from outside. A restart strobe from software clears the elapsed time. If the strobe does not arrive in time, the block requests a reset.

The block also filters a sampled manual-reset input from a push button. The input must be seen low on 10 consecutive ticks before it is accepted. Three events start a reset pulse: a watchdog expiry, an accepted button press, and the synchronous power-on reset. In every case the output is held low for a fixed 100 ticks. Other triggers are ignored while a pulse is running. When the pulse ends, the watchdog and the button filter both start again from zero.

Top module: `wdt_reset_gen`

## Requirements
- R1: `rst_req_n` is active low. It is 0 exactly while a reset pulse is in progress and 1 at all other times.
- R2: For a timeout code n from 1 to 30, the output goes low in the cycle after the (n*100)th tick since the window started, provided no restart strobe arrives in that window.
- R3: Code 0 behaves exactly like code 1, giving a 100-tick timeout.
- R4: Code 31 turns the watchdog off. No amount of ticks then causes a watchdog reset, and the elapsed count stays at zero.
- R5: A restart strobe clears the elapsed count to zero. A strobe that arrives in the same cycle as the expiring tick wins, so no reset is requested.
- R6: Once a pulse has begun, the output returns high in the cycle after the 100th tick counted during the pulse.
- R7: While a pulse is in progress, restart strobes and manual-reset activity have no effect on its length. After the pulse ends, both the watchdog count and the button filter start from zero.
- R8: If `mr_n` is sampled low on 10 consecutive ticks, a pulse starts in the cycle after the 10th tick. If `mr_n` is high on any tick, the filter count returns to zero.
- R9: While `rst` is high, the output is 0 from the next cycle on. After `rst` is released, the output stays low for 100 more ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| tick_ms | input | 1 | One-cycle strobe, once per millisecond |
| kick | input | 1 | Watchdog restart strobe |
| wdt_code | input | 5 | Timeout code: 0 means 100 ms, 1 to 30 means n×100 ms, 31 turns the watchdog off |
| mr_n | input | 1 | Sampled manual-reset input, active low |
| rst_req_n | output | 1 | Reset request, active low |

## Verification
Timeout codes 0, 1 and 2 are each run with no restart strobe, to separate the default-code handling from the n×100 scaling. A strobe placed partway through a window shows that the count is cleared and that the full timeout is measured again afterwards. A strobe on the exact expiring tick shows which of the two wins. Button patterns are tested in two ways: a 9-tick low run broken by one high sample, which must not trigger, and a low run held through a whole pulse, which shows the filter restarting at pulse end. Random mixes of tick density, strobes, button runs and code changes, including switches to and from code 31, are compared cycle by cycle against a model in the bench.

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen #(
  parameter int CODE_W      = 5,
  parameter int STEP_TICKS  = 100,
  parameter int PULSE_TICKS = 100,
  parameter int DEB_TICKS   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic              kick,
  input  logic [CODE_W-1:0] wdt_code,
  input  logic              mr_n,
  output logic              rst_req_n
);
  localparam int DIS_CODE = (1 << CODE_W) - 1;
  localparam int WD_W     = $clog2(DIS_CODE * STEP_TICKS + 1);
  localparam int PC_W     = $clog2(PULSE_TICKS + 1);
  localparam int DB_W     = $clog2(DEB_TICKS + 1);

  logic              pulse;
  logic [PC_W-1:0]   pc;
  logic [WD_W-1:0]   wd;
  logic [DB_W-1:0]   db;
  logic              wd_off, wd_hit, mr_hit, pc_end;
  logic [CODE_W-1:0] eff_code;
  logic [WD_W-1:0]   wd_lim;

  assign wd_off   = wdt_code == CODE_W'(DIS_CODE);
  assign eff_code = (wdt_code == '0) ? CODE_W'(1) : wdt_code;
  assign wd_lim   = WD_W'(eff_code) * WD_W'(STEP_TICKS);
  assign wd_hit   = tick_ms && !kick && !wd_off && (wd >= wd_lim - WD_W'(1));
  assign mr_hit   = tick_ms && !mr_n && (db == DB_W'(DEB_TICKS - 1));
  assign pc_end   = tick_ms && (pc == PC_W'(PULSE_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b1;
      pc    <= '0;
      wd    <= '0;
      db    <= '0;
    end else if (pulse) begin
      wd <= '0;
      db <= '0;
      if (pc_end) begin
        pulse <= 1'b0;
        pc    <= '0;
      end else if (tick_ms) begin
        pc <= pc + PC_W'(1);
      end
    end else if (wd_hit || mr_hit) begin
      pulse <= 1'b1;
      pc    <= '0;
      wd    <= '0;
      db    <= '0;
    end else begin
      if (kick || wd_off) wd <= '0;
      else if (tick_ms)   wd <= wd + WD_W'(1);
      if (tick_ms) db <= mr_n ? '0 : db + DB_W'(1);
    end
  end

  assign rst_req_n = ~pulse;

  p_por_low_r9: assert property (@(posedge clk) rst |=> !rst_req_n)
    else $error("R9 output not low after power-on reset");
  p_pulse_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !rst_req_n && !tick_ms |=> !rst_req_n)
    else $error("R6 pulse ended without a tick");
  p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_n) |-> $past(tick_ms))
    else $error("R6 pulse ended off a tick");
  p_off_no_reset_r4: assert property (@(posedge clk) disable iff (rst)
    rst_req_n && mr_n && wdt_code == CODE_W'(DIS_CODE) |=> rst_req_n)
    else $error("R4 reset while watchdog disabled");
  p_kick_wins_r5: assert property (@(posedge clk) disable iff (rst)
    rst_req_n && kick && mr_n |=> rst_req_n)
    else $error("R5 reset despite restart strobe");
  p_fall_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
    rst_req_n && !tick_ms |=> rst_req_n)
    else $error("R1 reset requested without a tick");
endmodule

// File: tb/wdt_reset_gen_test.sv
module wdt_reset_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_ms = 1'b0, kick = 1'b0, mr_n = 1'b1;
  logic [4:0] wdt_code = 5'd1;
  logic       rst_req_n;

  int vectors = 0, errors = 0;
  bit m_pulse;
  int m_pc, m_wd, m_db;

  always #10 clk = ~clk;

  wdt_reset_gen uut (.clk(clk), .rst(rst), .tick_ms(tick_ms), .kick(kick),
                     .wdt_code(wdt_code), .mr_n(mr_n), .rst_req_n(rst_req_n));

  function automatic int lim_of(input int code);
    return (code == 0 ? 1 : code) * 100;
  endfunction

  function automatic bit exp_out();
    return !m_pulse;
  endfunction

  task automatic model_next();
    bit trig = 0;
    if (rst) begin
      m_pulse = 1; m_pc = 0; m_wd = 0; m_db = 0;
    end else if (m_pulse) begin
      m_wd = 0; m_db = 0;
      if (tick_ms) begin
        if (m_pc == 99) begin m_pulse = 0; m_pc = 0; end
        else m_pc++;
      end
    end else begin
      if (kick || wdt_code == 31) m_wd = 0;
      else if (tick_ms) begin
        if (m_wd >= lim_of(wdt_code) - 1) trig = 1;
        else m_wd++;
      end
      if (tick_ms) begin
        if (!mr_n) begin
          if (m_db == 9) trig = 1; else m_db++;
        end else m_db = 0;
      end
      if (trig) begin m_pulse = 1; m_pc = 0; m_wd = 0; m_db = 0; end
    end
  endtask

  task automatic check(input string tag, input bit got, input bit exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: rst_req_n=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input bit t, input bit k, input bit m);
    tick_ms = t; kick = k; mr_n = m;
    model_next();
    @(negedge clk);
    check("R1/R2/R5/R8 model", rst_req_n, exp_out());
  endtask

  task automatic ticks(input int n, input bit m);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, m);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    step(0, 0, 1); step(0, 0, 1);
    check("R9 low under reset", rst_req_n, 1'b0);
    rst = 1'b0;
    ticks(99, 1);
    check("R9 pulse still held", rst_req_n, 1'b0);
    ticks(1, 1);
    check("R6 pulse ends on 100th tick", rst_req_n, 1'b1);

    wdt_code = 5'd0;
    ticks(99, 1);
    check("R3 code 0 before expiry", rst_req_n, 1'b1);
    ticks(1, 1);
    check("R3 code 0 expires at 100", rst_req_n, 1'b0);
    ticks(100, 1);
    check("R6 pulse length", rst_req_n, 1'b1);

    wdt_code = 5'd2;
    ticks(150, 1);
    step(0, 1, 1);
    ticks(199, 1);
    check("R5 count cleared by strobe", rst_req_n, 1'b1);
    ticks(1, 1);
    check("R2 code 2 expires at 200", rst_req_n, 1'b0);
    ticks(100, 1);

    wdt_code = 5'd1;
    ticks(99, 1);
    step(1, 1, 1);
    check("R5 strobe beats expiring tick", rst_req_n, 1'b1);
    ticks(99, 1);
    check("R5 window restarted", rst_req_n, 1'b1);
    ticks(1, 1);
    check("R2 code 1 expires", rst_req_n, 1'b0);
    ticks(100, 1);

    wdt_code = 5'd31;
    ticks(4000, 1);
    check("R4 disabled never resets", rst_req_n, 1'b1);

    ticks(9, 0);
    ticks(1, 1);
    ticks(9, 0);
    check("R8 broken low run ignored", rst_req_n, 1'b1);
    ticks(1, 0);
    check("R8 10th low tick accepted", rst_req_n, 1'b0);
    for (int i = 0; i < 100; i++) step(1'b1, i[0], 1'b0);
    check("R7 pulse length unaffected", rst_req_n, 1'b1);
    ticks(9, 0);
    check("R7 filter restarted after pulse", rst_req_n, 1'b1);
    ticks(1, 0);
    check("R7 filter counted from zero", rst_req_n, 1'b0);
    ticks(100, 1);

    wdt_code = 5'd1;
    ticks(99, 1);
    check("R7 watchdog restarted after pulse", rst_req_n, 1'b1);
    ticks(1, 1);
    check("R7 watchdog expiry from zero", rst_req_n, 1'b0);
    ticks(100, 1);

    begin
      int mr_run = 0;
      void'($urandom(32'h5eed));
      for (int i = 0; i < 40000; i++) begin
        if ($urandom_range(599) == 0) begin
          int pick = $urandom_range(4);
          wdt_code = (pick == 4) ? 5'd31 : 5'(pick);
        end
        if (mr_run == 0 && $urandom_range(799) == 0) mr_run = $urandom_range(30, 1);
        step($urandom_range(1) == 1, $urandom_range(249) == 0, mr_run == 0);
        if (mr_run > 0 && tick_ms) mr_run--;
      end
    end

    rst = 1'b1;
    step(0, 0, 1);
    check("R9 reset mid-run", rst_req_n, 1'b0);
    rst = 1'b0;
    ticks(100, 1);
    check("R9 pulse after release", rst_req_n, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule